// File: doc/BRIEF.md
# Bidirectional Latched Octal Transceiver

This block passes a byte-wide word between two buses, A and B, in either direction. Each direction has its own bank of level-sensitive storage and three active-low controls: chip enable, latch enable and output enable. With chip enable and latch enable both low, a bank is transparent and tracks its source bus. Raising either of them closes the bank, which then keeps the last value it saw. The far bus is driven from the bank only while chip enable and output enable of that direction are both low.

Each bus side is split into an input, a per-bit "driven" mask, an output and an output-enable, so the block needs no internal tri-states. A bit whose mask bit is clear reads as the last level it had while driven, which models a bus keeper. A power-good input clears all storage and holds both output enables off while it is low. A conflict flag rises whenever both sides would drive at once. The block has no clock: all storage is made of latches.

Top module: `bdx_xcvr`

## Requirements
- R1: With pwr_good high, ab_ce_n low and ab_le_n low, the A-to-B bank is transparent: when B is enabled, b_out equals the kept A value in the same settle.
- R2: A rise of ab_le_n (with ab_ce_n low) closes the A-to-B bank; later changes on A leave b_out at the value held before the rise.
- R3: A rise of ab_ce_n while ab_le_n is still low also closes the A-to-B bank, and the held value shows again when ab_ce_n returns low after ab_le_n has gone high.
- R4: b_oe is 1 exactly when pwr_good is high and ab_ce_n and ab_oe_n are both low; b_out equals the A-to-B bank contents while b_oe is 1 and is all zeros otherwise.
- R5: The B-to-A direction obeys R1 to R4 with ba_ce_n, ba_le_n, ba_oe_n, b_in/b_drv as source and a_out/a_oe as result.
- R6: A bit of a_in or b_in whose bit in a_drv or b_drv is 0 reads as the last value it had while its mask bit was 1 (0 if it was never driven since power-good rose).
- R7: While pwr_good is low, a_oe and b_oe are 0 and both banks and both keepers are cleared to zero; after pwr_good rises they read zero until loaded.
- R8: bus_conflict is 1 exactly when a_oe and b_oe are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pwr_good | input | 1 | High when supply is valid; low clears storage and disables outputs |
| a_in | input | W | Level present on bus A |
| a_drv | input | W | Per-bit mask, 1 where bus A is actively driven |
| b_in | input | W | Level present on bus B |
| b_drv | input | W | Per-bit mask, 1 where bus B is actively driven |
| ab_ce_n | input | 1 | A-to-B chip enable, active low |
| ab_le_n | input | 1 | A-to-B latch enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_ce_n | input | 1 | B-to-A chip enable, active low |
| ba_le_n | input | 1 | B-to-A latch enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| a_out | output | W | Value driven onto bus A (zero when disabled) |
| a_oe | output | 1 | Bus A driver enable |
| b_out | output | W | Value driven onto bus B (zero when disabled) |
| b_oe | output | 1 | Bus B driver enable |
| bus_conflict | output | 1 | Both buses driven at once |

## Verification
Every result is combinational through at most two latches, so each one is due in the same settle as the stimulus, with no cycle of delay. The bench changes inputs on the falling clock edge and compares outputs one nanosecond later, well before the next rising edge. Control changes and data changes go in separate steps, so that a latch closing and its data moving never coincide, and the bench's model only has to update its stored values in step order.

// File: rtl/bdx_pkg.sv
package bdx_pkg;

    typedef struct packed {
        logic ce_n;
        logic le_n;
        logic oe_n;
    } dir_ctrl_t;

    function automatic logic bank_open(dir_ctrl_t c);
        return !c.ce_n && !c.le_n;
    endfunction

    function automatic logic drive_on(dir_ctrl_t c, logic pg);
        return pg && !c.ce_n && !c.oe_n;
    endfunction

endpackage

// File: rtl/bdx_keeper.sv
module bdx_keeper #(
    parameter int W = 8
) (
    input  logic         pwr_good,
    input  logic [W-1:0] din,
    input  logic [W-1:0] drv,
    output logic [W-1:0] dout
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic kept;
        always_latch begin
            if (!pwr_good)
                kept = 1'b0;
            else if (drv[i])
                kept = din[i];
        end
        assign dout[i] = kept;
    end

    always_comb begin
        if (pwr_good) begin
            assert_keep_follow_R6: assert ((dout & drv) == (din & drv));
        end
    end

endmodule

// File: rtl/bdx_bank.sv
module bdx_bank #(
    parameter int W = 8
) (
    input  logic         pwr_good,
    input  logic         open,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_latch begin
        if (!pwr_good)
            q = '0;
        else if (open)
            q = d;
    end

    always_comb begin
        if (!pwr_good) begin
            assert_bank_clear_R7: assert (q == '0);
        end
        if (pwr_good && open) begin
            assert_bank_follow_R1: assert (q == d);
        end
    end

endmodule

// File: rtl/bdx_dir.sv
module bdx_dir
    import bdx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         pwr_good,
    input  dir_ctrl_t    ctrl,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         oe
);

    logic [W-1:0] held;
    logic         open;

    assign open = bank_open(ctrl);

    bdx_bank #(.W(W)) u_bank (
        .pwr_good (pwr_good),
        .open     (open),
        .d        (din),
        .q        (held)
    );

    assign oe   = drive_on(ctrl, pwr_good);
    assign dout = oe ? held : '0;

    always_comb begin
        if (!oe) begin
            assert_quiet_when_off_R4: assert (dout == '0);
        end else begin
            assert_drive_bank_R4: assert (dout == held);
        end
    end

endmodule

// File: rtl/bdx_xcvr.sv
module bdx_xcvr
    import bdx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         pwr_good,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] a_drv,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] b_drv,
    input  logic         ab_ce_n,
    input  logic         ab_le_n,
    input  logic         ab_oe_n,
    input  logic         ba_ce_n,
    input  logic         ba_le_n,
    input  logic         ba_oe_n,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    output logic         bus_conflict
);

    dir_ctrl_t    ab_ctrl;
    dir_ctrl_t    ba_ctrl;
    logic [W-1:0] a_kept;
    logic [W-1:0] b_kept;

    assign ab_ctrl = '{ce_n: ab_ce_n, le_n: ab_le_n, oe_n: ab_oe_n};
    assign ba_ctrl = '{ce_n: ba_ce_n, le_n: ba_le_n, oe_n: ba_oe_n};

    bdx_keeper #(.W(W)) u_keep_a (
        .pwr_good (pwr_good),
        .din      (a_in),
        .drv      (a_drv),
        .dout     (a_kept)
    );

    bdx_keeper #(.W(W)) u_keep_b (
        .pwr_good (pwr_good),
        .din      (b_in),
        .drv      (b_drv),
        .dout     (b_kept)
    );

    bdx_dir #(.W(W)) u_ab (
        .pwr_good (pwr_good),
        .ctrl     (ab_ctrl),
        .din      (a_kept),
        .dout     (b_out),
        .oe       (b_oe)
    );

    bdx_dir #(.W(W)) u_ba (
        .pwr_good (pwr_good),
        .ctrl     (ba_ctrl),
        .din      (b_kept),
        .dout     (a_out),
        .oe       (a_oe)
    );

    assign bus_conflict = a_oe & b_oe;

    always_comb begin
        if (!pwr_good) begin
            assert_hiz_powerdown_R7: assert (!a_oe && !b_oe);
        end
        if (bus_conflict) begin
            assert_conflict_ports_R8: assert (pwr_good && !ab_ce_n && !ab_oe_n
                                              && !ba_ce_n && !ba_oe_n);
        end
        if (b_oe) begin
            assert_b_enable_ports_R4: assert (!ab_ce_n && !ab_oe_n);
        end
        if (a_oe) begin
            assert_a_enable_ports_R5: assert (!ba_ce_n && !ba_oe_n);
        end
    end

endmodule

// File: tb/bdx_xcvr_bench.sv
module bdx_xcvr_bench;

    localparam int W = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         pwr_good;
    logic [W-1:0] a_in, a_drv, b_in, b_drv;
    logic         ab_ce_n, ab_le_n, ab_oe_n, ba_ce_n, ba_le_n, ba_oe_n;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe, bus_conflict;

    bdx_xcvr #(.W(W)) u_bdx_xcvr (
        .pwr_good     (pwr_good),
        .a_in         (a_in),
        .a_drv        (a_drv),
        .b_in         (b_in),
        .b_drv        (b_drv),
        .ab_ce_n      (ab_ce_n),
        .ab_le_n      (ab_le_n),
        .ab_oe_n      (ab_oe_n),
        .ba_ce_n      (ba_ce_n),
        .ba_le_n      (ba_le_n),
        .ba_oe_n      (ba_oe_n),
        .a_out        (a_out),
        .a_oe         (a_oe),
        .b_out        (b_out),
        .b_oe         (b_oe),
        .bus_conflict (bus_conflict)
    );

    int total = 0;
    int bad   = 0;

    // bench-side model state
    logic [W-1:0] m_ka, m_kb, m_ab, m_ba;

    task automatic model_update();
        if (!pwr_good) begin
            m_ka = '0; m_kb = '0; m_ab = '0; m_ba = '0;
        end else begin
            m_ka = (a_in & a_drv) | (m_ka & ~a_drv);
            m_kb = (b_in & b_drv) | (m_kb & ~b_drv);
            if (!ab_ce_n && !ab_le_n) m_ab = m_ka;
            if (!ba_ce_n && !ba_le_n) m_ba = m_kb;
        end
    endtask

    task automatic check(string tag);
        logic         eb_oe, ea_oe;
        logic [W-1:0] eb, ea;
        eb_oe = pwr_good && !ab_ce_n && !ab_oe_n;
        ea_oe = pwr_good && !ba_ce_n && !ba_oe_n;
        eb    = eb_oe ? m_ab : '0;
        ea    = ea_oe ? m_ba : '0;
        total++;
        if (b_oe !== eb_oe || b_out !== eb || a_oe !== ea_oe || a_out !== ea
            || bus_conflict !== (ea_oe && eb_oe)) begin
            bad++;
            $display("FAIL %s: got b_oe=%b b_out=%h a_oe=%b a_out=%h cf=%b exp b_oe=%b b_out=%h a_oe=%b a_out=%h cf=%b",
                     tag, b_oe, b_out, a_oe, a_out, bus_conflict,
                     eb_oe, eb, ea_oe, ea, ea_oe && eb_oe);
        end
    endtask

    task automatic set_ctrl(logic [2:0] ab, logic [2:0] ba, string tag);
        @(negedge clk);
        {ab_ce_n, ab_le_n, ab_oe_n} = ab;
        {ba_ce_n, ba_le_n, ba_oe_n} = ba;
        model_update();
        #1 check(tag);
    endtask

    task automatic set_data(logic [W-1:0] a, logic [W-1:0] ad,
                            logic [W-1:0] b, logic [W-1:0] bd, string tag);
        @(negedge clk);
        a_in = a; a_drv = ad; b_in = b; b_drv = bd;
        model_update();
        #1 check(tag);
    endtask

    task automatic set_pg(logic pg, string tag);
        @(negedge clk);
        pwr_good = pg;
        model_update();
        #1 check(tag);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got hung run exp completion");
        finish_run();
    end

    initial begin
        pwr_good = 1'b0;
        a_in = '0; a_drv = '0; b_in = '0; b_drv = '0;
        {ab_ce_n, ab_le_n, ab_oe_n} = 3'b111;
        {ba_ce_n, ba_le_n, ba_oe_n} = 3'b111;
        m_ka = '0; m_kb = '0; m_ab = '0; m_ba = '0;

        // R7: powered-down state, outputs off even with controls active
        set_ctrl(3'b000, 3'b000, "R7 powerdown");
        set_data(8'hA5, 8'hFF, 8'h3C, 8'hFF, "R7 powerdown data");
        set_ctrl(3'b111, 3'b111, "R7 idle");
        set_pg(1'b1, "R7 power up");
        // R7: storage reads zero after power-up when nothing is driven
        set_data(8'hFF, 8'h00, 8'hFF, 8'h00, "R7 R6 undriven");
        set_ctrl(3'b000, 3'b000, "R7 zero after powerup");
        set_ctrl(3'b111, 3'b111, "R7 idle");

        // R1 R4 R5 R6 R8: sweep all control combinations, two data patterns each
        for (int idx = 0; idx < 64; idx++) begin
            for (int p = 0; p < 2; p++) begin
                logic [W-1:0] av, bv, ad, bd;
                av = W'(idx * 37 + p * 91 + 5);
                bv = W'(~av ^ W'(idx));
                ad = (idx % 3 == 0) ? 8'h0F : 8'hFF;
                bd = (idx % 5 == 0) ? 8'hF0 : 8'hFF;
                set_data(av, ad, bv, bd, "R1 R4 R5 R6 R8 data");
            end
            set_ctrl(idx[5:3], idx[2:0], "R1 R4 R5 R8 ctrl");
        end

        // R2: rising latch enable holds the earlier value
        set_ctrl(3'b000, 3'b111, "R2 open");
        set_data(8'h5A, 8'hFF, 8'h00, 8'hFF, "R2 load");
        set_ctrl(3'b010, 3'b111, "R2 le rise");
        set_data(8'hC3, 8'hFF, 8'h00, 8'hFF, "R2 hold after change");

        // R3: chip enable rising while latch enable low closes the bank
        set_ctrl(3'b000, 3'b111, "R3 open");
        set_data(8'h11, 8'hFF, 8'h00, 8'hFF, "R3 load");
        set_ctrl(3'b100, 3'b111, "R3 ce rise");
        set_ctrl(3'b110, 3'b111, "R3 le rise under ce");
        set_data(8'h77, 8'hFF, 8'h00, 8'hFF, "R3 change A");
        set_ctrl(3'b010, 3'b111, "R3 reveal held");

        // R5: B-to-A mirror of R2 and R3
        set_ctrl(3'b111, 3'b000, "R5 open");
        set_data(8'h00, 8'hFF, 8'h96, 8'hFF, "R5 load");
        set_ctrl(3'b111, 3'b010, "R5 le rise");
        set_data(8'h00, 8'hFF, 8'h21, 8'hFF, "R5 hold");
        set_ctrl(3'b111, 3'b100, "R5 ce rise");
        set_ctrl(3'b111, 3'b010, "R5 reveal held");

        // R6: partially driven bus keeps undriven bits
        set_ctrl(3'b000, 3'b000, "R6 open both");
        set_data(8'hF0, 8'hFF, 8'h0F, 8'hFF, "R6 drive all");
        set_data(8'h05, 8'h0F, 8'hA0, 8'hF0, "R6 partial drive");
        set_data(8'h00, 8'h00, 8'hFF, 8'h00, "R6 release all");

        // R8: conflict only with both drivers on
        set_ctrl(3'b000, 3'b001, "R8 only B driven");
        set_ctrl(3'b010, 3'b010, "R8 both driven");

        // R7: power cycle clears everything
        set_pg(1'b0, "R7 power down");
        set_pg(1'b1, "R7 power up again");
        set_ctrl(3'b010, 3'b010, "R7 cleared banks");

        finish_run();
    end

endmodule